// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block derives the bit timing of a CAN node from the system clock and the serial receive line. A programmable prescaler turns the clock into time quanta. Each bit is split into a one-quantum sync segment, a first phase segment and a second phase segment. The unit marks the sample point at the end of the first phase segment. It marks the transmit point one clock before the next bit's sync segment begins, so the transmit logic can drive the line in time.

The unit follows the bus on falling (recessive-to-dominant) edges of the received line. While the bus is idle, or during the last bit of the intermission field, such an edge triggers a hard synchronization. At other times it triggers a resynchronization, which stretches or trims the current bit by at most the programmed jump width. A resynchronization is skipped on the clock where the node starts transmitting, but stays active for the rest of a transmission. The sampled bit is taken either from one sample or from a majority vote of three samples. The frame decoder uses the sampled bit, the previously sampled bit and the strobes.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2*(baudPresc+1) clocks. With no falling edge on the line, consecutive samplePoint pulses are (3+timeSeg1+timeSeg2) quanta apart, and each samplePoint pulse lasts one clock.
- R2: txPoint is a one-clock pulse that appears (timeSeg2+1) quanta minus one clock after samplePoint. It never coincides with samplePoint.
- R3: A falling edge on rxIn while busIdle or lastInterBit is 1 gives a one-clock hardSync pulse on the second clock edge after rxIn falls. The next samplePoint follows hardSync by (timeSeg1+1) quanta. When neither flag is set, no hardSync occurs.
- R4: A resynchronizing edge seen in quantum k (counting from 0) of the first phase segment lengthens that segment by min(k+1, syncJumpWidth+1) quanta.
- R5: A resynchronizing edge in the second phase segment, with r quanta of the segment left (the current quantum included), works as follows. If r > syncJumpWidth+1, the segment is trimmed by syncJumpWidth+1 quanta. Otherwise the bit ends at once and the first phase segment restarts, so the next samplePoint follows (timeSeg1+1) quanta after the edge is acted on.
- R6: Only falling edges synchronize. A rising edge on rxIn leaves the timing unchanged.
- R7: At most one synchronization is performed per bit. Further falling edges are ignored until the next samplePoint.
- R8: A falling edge acted on in the same clock where transmitting rises from 0 to 1 causes no synchronization.
- R9: Resynchronization still takes place while transmitting stays at 1.
- R10: With tripleSample at 0, sampledBit is the registered line value at the sample point. With tripleSample at 1, it is the majority of the values at the sample point and at the two preceding quantum boundaries. sampledBit changes only together with samplePoint.
- R11: At every samplePoint, sampledBitPrev takes the value sampledBit held just before.
- R12: Reset clears samplePoint, txPoint and hardSync and sets sampledBit and sampledBitPrev to 1. The internal line register resets to 1 (recessive), so a line held at 0 through reset with busIdle at 1 yields a hardSync two clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| rxIn | input | 1 | Serial receive line, 1 = recessive |
| baudPresc | input | 6 | Prescaler; quantum = 2*(value+1) clocks |
| syncJumpWidth | input | 2 | Maximum resync correction minus one, in quanta |
| timeSeg1 | input | 4 | First phase segment length minus one, in quanta |
| timeSeg2 | input | 3 | Second phase segment length minus one, in quanta |
| tripleSample | input | 1 | 1 = three-sample majority vote |
| busIdle | input | 1 | Bus idle flag from the frame decoder |
| transmitting | input | 1 | Node is transmitting |
| lastInterBit | input | 1 | Current bit is the last intermission bit |
| samplePoint | output | 1 | One-clock strobe at the sample point |
| sampledBit | output | 1 | Value taken at the latest sample point |
| sampledBitPrev | output | 1 | Value taken at the sample point before |
| txPoint | output | 1 | One-clock strobe, one clock before bit start |
| hardSync | output | 1 | One-clock pulse on a hard synchronization |

## Verification
The bench measures intervals between strobes in clocks. It places falling edges in chosen quanta: early and late in the first phase segment, and both trimmable and bit-ending positions in the second. A wrong phase-error limit, a missing segment restart or an off-by-one quantum count would each move the next sample point by a whole number of quanta. It also checks these cases:
- a second edge within the same bit, which would stretch the bit twice if the one-sync-per-bit lock were missing;
- an edge that coincides with the start of transmission, which would wrongly shift the bit if that skip were missing;
- a single-quantum glitch at the sample point, which a broken majority vote would let through.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;

  // Where the unit stands within the current bit.
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } phase_e;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic restartQ;   // restart the quantum prescaler now
    logic sampleNow;  // capture the bit at this quantum boundary
  } dpStrobe_t;

endpackage

// File: rtl/cbt_datapath.sv
`timescale 1ns/1ps
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxIn,
  input  logic [BRP_W-1:0] baudPresc,
  input  logic             tripleSample,
  input  dpStrobe_t        strobe,
  output logic             qTick,
  output logic             preTick,
  output logic             fallEdge,
  output logic             sampledBit,
  output logic             sampledBitPrev
);

  localparam int CW = BRP_W + 1;

  logic [CW-1:0] clkCnt;
  logic [CW-1:0] qLimit;
  logic          rxReg;
  logic          rxPrev;
  logic [1:0]    win;
  logic          vote;

  // Last count of a quantum: 2*(presc+1)-1.
  assign qLimit  = {baudPresc, 1'b1};
  assign qTick   = (clkCnt >= qLimit);
  assign preTick = (clkCnt == (qLimit - CW'(1)));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      clkCnt <= '0;
    end else if (strobe.restartQ || qTick) begin
      clkCnt <= '0;
    end else begin
      clkCnt <= clkCnt + CW'(1);
    end
  end

  // Line register and edge history both start recessive.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxReg  <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxReg  <= rxIn;
      rxPrev <= rxReg;
    end
  end

  assign fallEdge = rxPrev & ~rxReg;

  // Samples taken at the two previous quantum boundaries.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      win <= 2'b11;
    end else if (qTick) begin
      win <= {win[0], rxReg};
    end
  end

  always_comb begin
    if (tripleSample) begin
      vote = (win[1] & win[0]) | (win[1] & rxReg) | (win[0] & rxReg);
    end else begin
      vote = rxReg;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sampledBit     <= 1'b1;
      sampledBitPrev <= 1'b1;
    end else if (strobe.sampleNow) begin
      sampledBit     <= vote;
      sampledBitPrev <= sampledBit;
    end
  end

endmodule

// File: rtl/cbt_ctrl.sv
`timescale 1ns/1ps
module cbt_ctrl
  import cbt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qTick,
  input  logic             preTick,
  input  logic             fallEdge,
  input  logic [SJW_W-1:0] syncJumpWidth,
  input  logic [TS1_W-1:0] timeSeg1,
  input  logic [TS2_W-1:0] timeSeg2,
  input  logic             busIdle,
  input  logic             transmitting,
  input  logic             lastInterBit,
  output dpStrobe_t        strobe,
  output logic             samplePoint,
  output logic             txPoint,
  output logic             hardSync
);

  localparam int SW  = SJW_W + 1;
  localparam int TSW = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int QW  = ((TSW > SJW_W) ? TSW : SJW_W) + 2;

  phase_e        phase;
  logic [QW-1:0] qCnt;
  logic [SW-1:0] extend;
  logic [SW-1:0] shorten;
  logic          blocked;
  logic          txPrev;

  logic          txStart, hsWindow, doHard, canResync;
  logic [SW-1:0] sjwQ, lateCorr;
  logic [QW-1:0] seg1Target, seg2Target, remain, qNext;
  logic          seg1Last, seg2Last;
  logic          lateFix, earlyRestart, earlyTrim, restartQ, sampleNow, txNow;

  assign txStart   = transmitting & ~txPrev;
  assign hsWindow  = busIdle | lastInterBit;
  assign doHard    = fallEdge & hsWindow & ~txStart;
  assign canResync = fallEdge & ~hsWindow & ~txStart & ~blocked;

  assign sjwQ       = {1'b0, syncJumpWidth} + SW'(1);
  assign seg1Target = QW'(timeSeg1) + QW'(extend);
  assign seg2Target = QW'(timeSeg2) - QW'(shorten);
  assign remain     = QW'(timeSeg2) + QW'(1) - qCnt;
  assign qNext      = qCnt + QW'(1);

  assign seg1Last = (phase == PH_SEG1) && (qCnt >= seg1Target);
  assign seg2Last = (phase == PH_SEG2) && (qCnt >= seg2Target);

  // Late edge: correction grows with the quantum it lands in, capped at the jump width.
  always_comb begin
    if (qNext < QW'(sjwQ)) begin
      lateCorr = qNext[SW-1:0];
    end else begin
      lateCorr = sjwQ;
    end
  end

  assign lateFix      = canResync && (phase == PH_SEG1) && !(qTick && seg1Last);
  assign earlyRestart = canResync && (phase == PH_SEG2) && (remain <= QW'(sjwQ));
  assign earlyTrim    = canResync && (phase == PH_SEG2) && !earlyRestart;
  assign restartQ     = doHard | earlyRestart;
  assign sampleNow    = qTick & seg1Last & ~restartQ;
  assign txNow        = preTick & seg2Last & ~restartQ;

  assign strobe.restartQ  = restartQ;
  assign strobe.sampleNow = sampleNow;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase       <= PH_SYNC;
      qCnt        <= '0;
      extend      <= '0;
      shorten     <= '0;
      blocked     <= 1'b0;
      txPrev      <= 1'b0;
      samplePoint <= 1'b0;
      txPoint     <= 1'b0;
      hardSync    <= 1'b0;
    end else begin
      txPrev      <= transmitting;
      samplePoint <= sampleNow;
      txPoint     <= txNow;
      hardSync    <= doHard;
      if (restartQ) begin
        // The edge itself becomes the sync segment.
        phase   <= PH_SEG1;
        qCnt    <= '0;
        extend  <= '0;
        shorten <= '0;
        blocked <= 1'b1;
      end else begin
        if (lateFix) begin
          extend  <= lateCorr;
          blocked <= 1'b1;
        end
        if (earlyTrim) begin
          shorten <= sjwQ;
          blocked <= 1'b1;
        end
        if (canResync && (phase == PH_SYNC)) begin
          blocked <= 1'b1;
        end
        if (qTick) begin
          case (phase)
            PH_SYNC: begin
              phase <= PH_SEG1;
              qCnt  <= '0;
            end
            PH_SEG1: begin
              if (seg1Last) begin
                phase   <= PH_SEG2;
                qCnt    <= '0;
                blocked <= 1'b0;
              end else begin
                qCnt <= qNext;
              end
            end
            PH_SEG2: begin
              if (seg2Last) begin
                phase   <= PH_SYNC;
                qCnt    <= '0;
                extend  <= '0;
                shorten <= '0;
              end else begin
                qCnt <= qNext;
              end
            end
            default: begin
              phase <= PH_SYNC;
              qCnt  <= '0;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/can_bit_timing.sv
`timescale 1ns/1ps
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxIn,
  input  logic [BRP_W-1:0] baudPresc,
  input  logic [SJW_W-1:0] syncJumpWidth,
  input  logic [TS1_W-1:0] timeSeg1,
  input  logic [TS2_W-1:0] timeSeg2,
  input  logic             tripleSample,
  input  logic             busIdle,
  input  logic             transmitting,
  input  logic             lastInterBit,
  output logic             samplePoint,
  output logic             sampledBit,
  output logic             sampledBitPrev,
  output logic             txPoint,
  output logic             hardSync
);

  dpStrobe_t strobe;
  logic      qTick;
  logic      preTick;
  logic      fallEdge;

  cbt_datapath #(
    .BRP_W(BRP_W)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .rxIn          (rxIn),
    .baudPresc     (baudPresc),
    .tripleSample  (tripleSample),
    .strobe        (strobe),
    .qTick         (qTick),
    .preTick       (preTick),
    .fallEdge      (fallEdge),
    .sampledBit    (sampledBit),
    .sampledBitPrev(sampledBitPrev)
  );

  cbt_ctrl #(
    .SJW_W(SJW_W),
    .TS1_W(TS1_W),
    .TS2_W(TS2_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .qTick        (qTick),
    .preTick      (preTick),
    .fallEdge     (fallEdge),
    .syncJumpWidth(syncJumpWidth),
    .timeSeg1     (timeSeg1),
    .timeSeg2     (timeSeg2),
    .busIdle      (busIdle),
    .transmitting (transmitting),
    .lastInterBit (lastInterBit),
    .strobe       (strobe),
    .samplePoint  (samplePoint),
    .txPoint      (txPoint),
    .hardSync     (hardSync)
  );

endmodule

// File: rtl/can_bit_timing_checker.sv
`timescale 1ns/1ps
module can_bit_timing_checker (
  input logic clk,
  input logic rst,
  input logic samplePoint,
  input logic txPoint,
  input logic hardSync,
  input logic sampledBit,
  input logic sampledBitPrev
);

  // R1: the sample strobe is one clock wide
  a_r1_sample_pulse: assert property (@(posedge clk) disable iff (rst)
    samplePoint |=> !samplePoint);

  // R2: the transmit and sample strobes are never high together
  a_r2_tx_apart: assert property (@(posedge clk) disable iff (rst)
    !(samplePoint && txPoint));

  // R3: the hard synchronization pulse is one clock wide
  a_r3_hs_pulse: assert property (@(posedge clk) disable iff (rst)
    hardSync |=> !hardSync);

  // R10: the sampled bit moves only with a sample strobe
  a_r10_bit_held: assert property (@(posedge clk) disable iff (rst)
    !samplePoint |-> $stable(sampledBit));

  // R11: the previous bit is the value held before the sample
  a_r11_prev_follows: assert property (@(posedge clk) disable iff (rst)
    samplePoint |-> (sampledBitPrev == $past(sampledBit)));

endmodule

bind can_bit_timing can_bit_timing_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .samplePoint   (samplePoint),
  .txPoint       (txPoint),
  .hardSync      (hardSync),
  .sampledBit    (sampledBit),
  .sampledBitPrev(sampledBitPrev)
);

// File: tb/tb_can_bit_timing.sv
`timescale 1ns/1ps
module tb_can_bit_timing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxIn = 1'b0;
  logic [5:0] baudPresc = 6'd1;
  logic [1:0] syncJumpWidth = 2'd1;
  logic [3:0] timeSeg1 = 4'd5;
  logic [2:0] timeSeg2 = 3'd4;
  logic       tripleSample = 1'b0;
  logic       busIdle = 1'b1;
  logic       transmitting = 1'b0;
  logic       lastInterBit = 1'b0;
  logic       samplePoint, sampledBit, sampledBitPrev, txPoint, hardSync;

  int nTests = 0;
  int nFail  = 0;

  can_bit_timing dut (
    .clk(clk), .rst(rst), .rxIn(rxIn), .baudPresc(baudPresc),
    .syncJumpWidth(syncJumpWidth), .timeSeg1(timeSeg1), .timeSeg2(timeSeg2),
    .tripleSample(tripleSample), .busIdle(busIdle), .transmitting(transmitting),
    .lastInterBit(lastInterBit), .samplePoint(samplePoint), .sampledBit(sampledBit),
    .sampledBitPrev(sampledBitPrev), .txPoint(txPoint), .hardSync(hardSync)
  );

  always #4 clk = ~clk;

  // {presc, sjw, tseg1, tseg2, hardSync->sample, sample->tx, sample->sample}
  localparam int VEC [4][7] = '{
    '{0, 0, 1, 1,  4,  3,  10},
    '{1, 1, 3, 2, 16, 11,  32},
    '{2, 3, 5, 4, 36, 29,  72},
    '{3, 2, 7, 7, 64, 63, 136}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel 0 = samplePoint, 1 = txPoint, 2 = hardSync; counts negedges until seen
  task automatic waitSig(input int sel, output int cnt);
    bit seen;
    cnt  = 0;
    seen = 1'b0;
    while (!seen && cnt < 4000) begin
      @(negedge clk);
      cnt++;
      case (sel)
        0:       seen = samplePoint;
        1:       seen = txPoint;
        default: seen = hardSync;
      endcase
    end
    if (!seen) check(1'b0, "timeout", cnt, -1);
  endtask

  task automatic setCfg(input int p, input int j, input int s1, input int s2);
    baudPresc     = 6'(p);
    syncJumpWidth = 2'(j);
    timeSeg1      = 4'(s1);
    timeSeg2      = 3'(s2);
  endtask

  // R3: falling edge inside the hard-sync window
  task automatic doHardSync(input bit viaLast);
    int c;
    rxIn         = 1'b1;
    busIdle      = !viaLast;
    lastInterBit = viaLast;
    tick(3);
    rxIn = 1'b0;
    waitSig(2, c);
    check(c == 2, viaLast ? "R3 last-intermission hardSync delay" : "R3 idle hardSync delay", c, 2);
    busIdle      = 1'b0;
    lastInterBit = 1'b0;
  endtask

  // After a hard sync and its first sample, drive edges at negedge counts and measure the next interval.
  task automatic resyncCase(input string req, input int rise1, input int fall1,
                            input int rise2, input int fall2, input int txAt, input int expGap);
    int c;
    int n;
    int gap;
    doHardSync(1'b0);
    waitSig(0, c);
    n   = 0;
    gap = -1;
    while (n < 400 && gap < 0) begin
      if (n > 0 && samplePoint) begin
        gap = n;
      end else begin
        if (n == rise1) rxIn = 1'b1;
        if (n == fall1) rxIn = 1'b0;
        if (n == rise2) rxIn = 1'b1;
        if (n == fall2) rxIn = 1'b0;
        if (n == txAt)  transmitting = 1'b1;
        @(negedge clk);
        n++;
      end
    end
    check(gap == expGap, req, gap, expGap);
  endtask

  task automatic glitchCase(input bit triple, input int hiFrom, input int hiTo, input int expBit,
                            input string req);
    int n;
    int c;
    tripleSample = triple;
    doHardSync(1'b0);
    for (n = 0; n < hiTo + 1; n++) begin
      if (n == hiFrom) rxIn = 1'b1;
      if (n == hiTo)   rxIn = 1'b0;
      if (n < hiTo) @(negedge clk);
    end
    waitSig(0, c);
    check(sampledBit == 1'(expBit), req, int'(sampledBit), expBit);
  endtask

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int c;
    int hsCount;
    // R12: reset values, line register resets recessive
    tick(3);
    check(samplePoint == 1'b0, "R12 samplePoint in reset", int'(samplePoint), 0);
    check(txPoint == 1'b0, "R12 txPoint in reset", int'(txPoint), 0);
    check(hardSync == 1'b0, "R12 hardSync in reset", int'(hardSync), 0);
    check(sampledBit == 1'b1, "R12 sampledBit in reset", int'(sampledBit), 1);
    check(sampledBitPrev == 1'b1, "R12 sampledBitPrev in reset", int'(sampledBitPrev), 1);
    rst = 1'b0;
    waitSig(2, c);
    check(c == 2, "R12 hardSync from recessive reset value", c, 2);

    // Table walk: R1, R2, R3 across timing settings
    for (int i = 0; i < 4; i++) begin
      setCfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      doHardSync(1'b0);
      waitSig(0, c);
      check(c == VEC[i][4], "R3 hardSync to samplePoint", c, VEC[i][4]);
      waitSig(1, c);
      check(c == VEC[i][5], "R2 samplePoint to txPoint", c, VEC[i][5]);
      waitSig(0, c);
      check(c + VEC[i][5] == VEC[i][6], "R1 bit period", c + VEC[i][5], VEC[i][6]);
    end

    // Directed cases: quantum 4 clocks, jump 2 quanta, seg1 6 quanta, seg2 5 quanta, bit 48 clocks
    setCfg(1, 1, 5, 4);
    resyncCase("R6 rising edge ignored", 8, -1, -1, -1, -1, 48);
    resyncCase("R4 late edge quantum 0", 0, 24, -1, -1, -1, 52);
    resyncCase("R4 late edge capped by jump width", 0, 36, -1, -1, -1, 56);
    resyncCase("R5 early edge trims seg2", 0, 8, -1, -1, -1, 40);
    resyncCase("R5 early edge restarts seg1", 0, 16, -1, -1, -1, 42);
    resyncCase("R7 second edge in same bit ignored", 0, 24, 28, 32, -1, 52);
    resyncCase("R8 no resync as transmission starts", 0, 24, -1, -1, 25, 48);
    transmitting = 1'b0;
    transmitting = 1'b1;
    tick(4);
    resyncCase("R9 resync while transmitting", 0, 24, -1, -1, -1, 52);
    transmitting = 1'b0;

    // R3: last intermission bit also allows hard sync; no window, no hard sync
    doHardSync(1'b1);
    rxIn = 1'b1;
    busIdle = 1'b0;
    tick(4);
    rxIn = 1'b0;
    hsCount = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (hardSync) hsCount++;
    end
    check(hsCount == 0, "R3 no hardSync outside window", hsCount, 0);

    // R10 / R11: sample-point glitch, single versus triple
    glitchCase(1'b0, 22, 23, 1, "R10 single sample takes glitch");
    waitSig(0, c);
    check(sampledBit == 1'b0, "R10 single sample next bit", int'(sampledBit), 0);
    check(sampledBitPrev == 1'b1, "R11 previous bit kept", int'(sampledBitPrev), 1);
    glitchCase(1'b1, 22, 23, 0, "R10 triple vote rejects glitch");
    glitchCase(1'b1, 18, 23, 1, "R10 triple vote two of three");
    tripleSample = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule